// File: doc/BRIEF.md
# Serial Synthesizer Configuration Receiver

This block is a three-wire serial slave that takes in one 32-bit configuration word for a fractional-N clock synthesizer. A host raises the select line, clocks in the word one bit per serial-clock rising edge, then drops select. The three serial lines are asynchronous to the block. Each one passes through a synchronizer into a faster system clock, and all edge detection happens in that domain.

When select falls, the receiver checks the frame. A good frame has exactly 32 bits and both of its fixed-zero fields at zero. If the frame is good, all configuration fields update in a single cycle, and a one-cycle start pulse tells the synthesizer to reacquire lock. A bad frame keeps the old fields, raises an error flag and sends no pulse. A select pulse with no serial clocks in it requests reacquisition with the program already held.

The fields are:
- the two pattern counts (cycles at the full divisor and at the divisor minus one),
- the 4-bit integer divisor code, plus its decoded value,
- the output post-divider code,
- the two wrapper ratio codes, which are passed through unchanged.

The control path is a three-state machine:
- IDLE: waits for select high. The transition IDLE→SHIFT clears the bit counter.
- SHIFT: shifts in one bit per synchronized serial-clock rising edge. The transition SHIFT→COMMIT is taken when synchronized select goes low.
- COMMIT: lasts one cycle and decides between accept, retrigger and reject. The transition COMMIT→IDLE is unconditional.

Top module: `cfg_serial_rx`

## Requirements
- R1: After reset, every field output is zero, `p_value` is 17, and `acq_start` and `frame_err` are low.
- R2: A data bit is taken only on a serial-clock rising edge while select is high. Serial clock and data activity while select is low changes no output and adds no bit to the next frame.
- R3: Bits arrive MSB first. In arrival order the frame is: 4 zero bits, `qhi_cnt` (5), `qlo_cnt` (5), `p_code` (4), 3 zero bits, `post_code` (5), `num_code` (3), `den_code` (3). Counting the first bit as bit 31, these fields sit at bits [31:28], [27:23], [22:18], [17:14], [13:11], [10:6], [5:3] and [2:0].
- R4: A good frame loads all field outputs in the same cycle, within 8 system clocks of select falling. Field outputs never change in any cycle in which `acq_start` is low.
- R5: A good frame produces exactly one `acq_start` pulse, and that pulse lasts one system clock.
- R6: A select pulse with no serial-clock edges produces one `acq_start` pulse, leaves the fields unchanged and clears `frame_err`.
- R7: A frame with 1 to 31 bits, or with more than 32 bits, sets `frame_err`, produces no pulse and keeps the previous fields.
- R8: A 32-bit frame with a nonzero bit in the leading 4-bit field or in the 3-bit field at [13:11] is rejected as in R7.
- R9: `p_value` equals 17 plus `p_code`, so it always lies between 17 and 32.
- R10: `frame_err` holds until the next accepted commit (a good frame or a retrigger) and clears in the cycle of that commit's `acq_start` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_in | input | 1 | Serial select, active high, asynchronous |
| sclk_in | input | 1 | Serial clock, asynchronous |
| sdat_in | input | 1 | Serial data, asynchronous |
| qhi_cnt | output | 5 | Count of reference periods at the full divisor |
| qlo_cnt | output | 5 | Count of reference periods at the divisor minus one |
| p_code | output | 4 | Integer divisor code |
| p_value | output | 6 | Decoded integer divisor, 17 to 32 |
| post_code | output | 5 | Output post-divider code |
| num_code | output | 3 | Wrapper numerator divider code |
| den_code | output | 3 | Wrapper denominator divider code |
| acq_start | output | 1 | One-cycle pulse requesting frequency acquisition |
| frame_err | output | 1 | Last commit attempt was rejected |

## Verification
The assertions rely on three properties of the inputs:
- Each serial-clock level and each data bit stays stable for several system clocks.
- Select rises well before the first serial-clock edge.
- Select falls well after the last serial-clock edge.

Under these conditions, the synchronized select and serial clock never change in the same system cycle. The bench holds each serial-clock phase for 16 system clocks (80 ns) and leaves at least that gap on both sides of every select edge. This stays within the stated minimum serial-clock timing.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

    localparam int FRAME_BITS = 32;
    localparam int PRE_W      = 4;
    localparam int QP_W       = 5;
    localparam int DIV_W      = 4;
    localparam int RSV_W      = 3;
    localparam int POST_W     = 5;
    localparam int RAT_W      = 3;
    localparam int P_BASE     = 17;
    localparam int P_W        = 6;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    // Field offsets within the assembled word (last bit received is bit 0)
    localparam int DEN_LSB  = 0;
    localparam int NUM_LSB  = DEN_LSB + RAT_W;
    localparam int POST_LSB = NUM_LSB + RAT_W;
    localparam int RSV_LSB  = POST_LSB + POST_W;
    localparam int DIV_LSB  = RSV_LSB + RSV_W;
    localparam int QLO_LSB  = DIV_LSB + DIV_W;
    localparam int QHI_LSB  = QLO_LSB + QP_W;
    localparam int PRE_LSB  = QHI_LSB + QP_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic [QP_W-1:0]   qhi;
        logic [QP_W-1:0]   qlo;
        logic [DIV_W-1:0]  div;
        logic [POST_W-1:0] post;
        logic [RAT_W-1:0]  num;
        logic [RAT_W-1:0]  den;
    } cfg_fields_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int W     = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             din,
    output logic [W-1:0]     word,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(W + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt  <= '0;
        end else if (shift) begin
            word <= {word[W-2:0], din};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_pdec.sv
module cfg_pdec #(
    parameter int CODE_W = 4,
    parameter int BASE   = 17,
    parameter int OUT_W  = 6
) (
    input  logic [CODE_W-1:0] code,
    output logic [OUT_W-1:0]  value
);

    localparam logic [OUT_W-1:0] BASE_V = OUT_W'(BASE);

    always_comb begin
        value = BASE_V + OUT_W'(code);
    end

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
    import cfg_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_in,
    input  logic              sclk_in,
    input  logic              sdat_in,
    output logic [QP_W-1:0]   qhi_cnt,
    output logic [QP_W-1:0]   qlo_cnt,
    output logic [DIV_W-1:0]  p_code,
    output logic [P_W-1:0]    p_value,
    output logic [POST_W-1:0] post_code,
    output logic [RAT_W-1:0]  num_code,
    output logic [RAT_W-1:0]  den_code,
    output logic              acq_start,
    output logic              frame_err
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

    // ---------------- input synchronization and edge detect ----------------
    logic [2:0] pins_s;
    logic       sel_hi, sclk_s, sdat_s, sclk_q, sclk_rise;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({sel_in, sclk_in, sdat_in}),
        .q_sync (pins_s)
    );

    assign sel_hi = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdat_s = pins_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_q;

    // ---------------- state machine ----------------
    rx_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sel_hi)  state_nx = ST_SHIFT;
            ST_SHIFT:  if (!sel_hi) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- frame assembly ----------------
    logic [FRAME_BITS-1:0] word;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  sh_clr, sh_en;

    assign sh_clr = (state == ST_IDLE) && sel_hi;
    assign sh_en  = (state == ST_SHIFT) && sel_hi && sclk_rise;

    cfg_shifter #(.W(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sh_clr),
        .shift(sh_en),
        .din  (sdat_s),
        .word (word),
        .cnt  (bit_cnt)
    );

    // ---------------- frame qualification ----------------
    logic        pre_zero, rsv_zero, frame_good, retrigger;
    cfg_fields_t incoming, held;

    assign pre_zero   = (word[PRE_LSB +: PRE_W] == '0);
    assign rsv_zero   = (word[RSV_LSB +: RSV_W] == '0);
    assign frame_good = (bit_cnt == FULL_CNT) && pre_zero && rsv_zero;
    assign retrigger  = (bit_cnt == '0);

    always_comb begin
        incoming.qhi  = word[QHI_LSB  +: QP_W];
        incoming.qlo  = word[QLO_LSB  +: QP_W];
        incoming.div  = word[DIV_LSB  +: DIV_W];
        incoming.post = word[POST_LSB +: POST_W];
        incoming.num  = word[NUM_LSB  +: RAT_W];
        incoming.den  = word[DEN_LSB  +: RAT_W];
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= '0;
            acq_start <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            acq_start <= 1'b0;
            if (state == ST_COMMIT) begin
                if (retrigger) begin
                    acq_start <= 1'b1;
                    frame_err <= 1'b0;
                end else if (frame_good) begin
                    held      <= incoming;
                    acq_start <= 1'b1;
                    frame_err <= 1'b0;
                end else begin
                    frame_err <= 1'b1;
                end
            end
        end
    end

    assign qhi_cnt   = held.qhi;
    assign qlo_cnt   = held.qlo;
    assign p_code    = held.div;
    assign post_code = held.post;
    assign num_code  = held.num;
    assign den_code  = held.den;

    cfg_pdec #(.CODE_W(DIV_W), .BASE(P_BASE), .OUT_W(P_W)) u_pdec (
        .code (held.div),
        .value(p_value)
    );

endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk
    import cfg_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [QP_W-1:0]   qhi_cnt,
    input logic [QP_W-1:0]   qlo_cnt,
    input logic [DIV_W-1:0]  p_code,
    input logic [P_W-1:0]    p_value,
    input logic [POST_W-1:0] post_code,
    input logic [RAT_W-1:0]  num_code,
    input logic [RAT_W-1:0]  den_code,
    input logic              acq_start,
    input logic              frame_err
);

    logic [QP_W*2+DIV_W+POST_W+RAT_W*2-1:0] all_fields;
    assign all_fields = {qhi_cnt, qlo_cnt, p_code, post_code, num_code, den_code};

    // R5
    pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |=> !acq_start);

    // R4
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_start |-> $stable(all_fields));

    // R7
    err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |-> !frame_err);

    // R10
    err_clear_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_err) |-> acq_start);

    // R9
    p_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_value >= P_W'(17)) && (p_value <= P_W'(32)));

endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .qhi_cnt  (qhi_cnt),
    .qlo_cnt  (qlo_cnt),
    .p_code   (p_code),
    .p_value  (p_value),
    .post_code(post_code),
    .num_code (num_code),
    .den_code (den_code),
    .acq_start(acq_start),
    .frame_err(frame_err)
);

// File: tb/sim_cfg_serial_rx.sv
`timescale 1ns/1ps
module sim_cfg_serial_rx;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_in = 1'b0, sclk_in = 1'b0, sdat_in = 1'b0;
    logic [4:0] qhi_cnt, qlo_cnt, post_code;
    logic [3:0] p_code;
    logic [5:0] p_value;
    logic [2:0] num_code, den_code;
    logic acq_start, frame_err;

    always #2.5 clk = ~clk;

    cfg_serial_rx u0 (
        .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .sclk_in(sclk_in), .sdat_in(sdat_in),
        .qhi_cnt(qhi_cnt), .qlo_cnt(qlo_cnt), .p_code(p_code), .p_value(p_value),
        .post_code(post_code), .num_code(num_code), .den_code(den_code),
        .acq_start(acq_start), .frame_err(frame_err)
    );

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int hi_cycles = 0;
    logic acq_prev = 1'b0;
    bit done = 0;

    always @(posedge clk) begin
        if (acq_start) hi_cycles++;
        if (acq_start && !acq_prev) pulses++;
        acq_prev = acq_start;
    end

    localparam int NV = 8;
    localparam logic [31:0] VWORD [NV] = '{
        {4'h0, 5'd2,  5'd7,  4'd6,  3'd0, 5'd4,  3'd5, 3'd5},
        {4'h0, 5'd11, 5'd7,  4'd7,  3'd0, 5'd20, 3'd5, 3'd5},
        {4'h0, 5'd31, 5'd0,  4'd15, 3'd0, 5'd31, 3'd7, 3'd7},
        {4'h8, 5'd3,  5'd3,  4'd3,  3'd0, 5'd3,  3'd3, 3'd3},
        {4'h0, 5'd4,  5'd4,  4'd4,  3'd2, 5'd4,  3'd4, 3'd4},
        {4'h0, 5'd9,  5'd9,  4'd9,  3'd0, 5'd9,  3'd1, 3'd1},
        {4'h0, 5'd21, 5'd21, 4'd10, 3'd0, 5'd10, 3'd2, 3'd6},
        {4'h0, 5'd1,  5'd24, 4'd0,  3'd0, 5'd21, 3'd6, 3'd2}
    };
    localparam int VBITS [NV] = '{32, 32, 32, 32, 32, 31, 33, 32};
    localparam bit VGOOD [NV] = '{1, 1, 1, 0, 0, 0, 0, 1};

    logic [31:0] exp_word = '0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] w, input int nbits);
        @(negedge clk);
        sel_in = 1'b1;
        wait_clks(16);
        for (int i = 0; i < nbits; i++) begin
            sdat_in = (i < 32) ? w[31-i] : 1'b0;
            wait_clks(16);
            sclk_in = 1'b1;
            wait_clks(16);
            sclk_in = 1'b0;
        end
        wait_clks(16);
        sel_in = 1'b0;
    endtask

    task automatic check_fields(input string req);
        check({req, " qhi"},  int'(qhi_cnt),   int'(exp_word[27:23]));
        check({req, " qlo"},  int'(qlo_cnt),   int'(exp_word[22:18]));
        check({req, " pc"},   int'(p_code),    int'(exp_word[17:14]));
        check({req, " post"}, int'(post_code), int'(exp_word[10:6]));
        check({req, " num"},  int'(num_code),  int'(exp_word[5:3]));
        check({req, " den"},  int'(den_code),  int'(exp_word[2:0]));
        check("R9 p_value",   int'(p_value),   17 + int'(exp_word[17:14]));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0;
        wait_clks(10);
        rst_n = 1'b1;
        wait_clks(4);

        // R1 reset state
        check_fields("R1 reset");
        check("R1 acq_start", int'(acq_start), 0);
        check("R1 frame_err", int'(frame_err), 0);

        // R3 R4 R5 R7 R8 table-driven frames
        for (int v = 0; v < NV; v++) begin
            p0 = pulses;
            send(VWORD[v], VBITS[v]);
            wait_clks(8);
            if (VGOOD[v]) exp_word = VWORD[v];
            check(VGOOD[v] ? "R5 pulse count" : "R7/R8 no pulse", pulses - p0, VGOOD[v] ? 1 : 0);
            check(VGOOD[v] ? "R10 err clear" : "R7 R8 err set", int'(frame_err), VGOOD[v] ? 0 : 1);
            check_fields(VGOOD[v] ? "R3 R4 field" : "R7 R8 held");
            wait_clks(8);
            check_fields("R4 stable");
        end
        check("R5 width", hi_cycles, pulses);

        // R8 error, then R6 retrigger with no clocks clears it
        send(VWORD[3], 32);
        wait_clks(8);
        check("R8 err", int'(frame_err), 1);
        p0 = pulses;
        send(32'h0, 0);
        wait_clks(8);
        check("R6 pulse", pulses - p0, 1);
        check("R6 R10 err", int'(frame_err), 0);
        check_fields("R6 held");

        // R2 serial activity with select low is ignored
        p0 = pulses;
        for (int i = 0; i < 40; i++) begin
            sdat_in = i[0];
            wait_clks(16);
            sclk_in = 1'b1;
            wait_clks(16);
            sclk_in = 1'b0;
        end
        wait_clks(8);
        check("R2 no pulse", pulses - p0, 0);
        check_fields("R2 held");
        send(32'h0, 0);
        wait_clks(8);
        check("R2 retrigger ok", int'(frame_err), 0);
        check("R2 pulse", pulses - p0, 1);
        check_fields("R2 after");
        check("R5 width", hi_cycles, pulses);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule